// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns bytes written by a host into asynchronous serial frames on one output line that idles high. It holds two registers. A holding register takes the host's byte. A shift register carries the frame that is currently going out. The host can therefore queue the next character while the current one is still on the line.

Two flags report progress. One shows that the holding register is free. The other shows that the line has gone quiet. Each flag drives an interrupt output through its own enable. The transmitter checks for pending data as it enters the stop bit. If a byte is waiting, that byte follows the stop bits with no idle bit in between. If nothing is waiting, the end flag is raised and the line stays at mark.

An external single-cycle enable, `baud_tick`, sets the bit period. Configuration inputs choose:
- 7 or 8 data bits
- parity off, even or odd
- a forced ninth "address" bit in place of parity
- 1 or 2 stop bits

Top module: `dbl_uart_tx`

## Requirements
- R1: After reset, `flag_empty` is 1, `flag_end` is 1 and `tx_line` is 1.
- R2: A cycle with `wr_en` high stores `wr_data` and, from the next cycle, holds both `flag_empty` and `flag_end` at 0.
- R3: With the line idle and data pending, the transmitter takes the data into the shift register on the next `baud_tick`, and `flag_empty` returns to 1 in the cycle after that tick.
- R4: `irq_empty` is high exactly when `flag_empty` is 1 and `irq_empty_en` is 1.
- R5: A frame is sent as follows. First a start bit of 0. Then the data bits, least significant first: bits [6:0] when `cfg_seven_bits` is 1, bits [7:0] otherwise. Then the optional extra bit. Then the stop bits, each 1.
- R6: If data is pending when the transmitter enters the first stop bit, that data is loaded at that moment. Its start bit then follows the last stop bit directly, with no idle bit.
- R7: If nothing is pending when the first stop bit begins, `flag_end` is set. After the stop bits the line stays at 1 until new data is loaded.
- R8: `irq_end` is high exactly when `flag_end` is 1 and `irq_end_en` is 1.
- R9: A write while `flag_empty` is 0 replaces the pending byte. Only the last byte written is sent.
- R10: When `cfg_parity_en` is 1 and `cfg_mpb_en` is 0, an extra bit follows the data. It makes the count of ones over the data bits and this bit even when `cfg_parity_odd` is 0, and odd when `cfg_parity_odd` is 1.
- R11: When `cfg_mpb_en` is 1, the extra bit equals `cfg_mpb_val`, whatever the parity settings are.
- R12: When `cfg_two_stop` is 1 the frame ends with two stop bits; otherwise it ends with one.
- R13: Each bit lasts exactly one `baud_tick` interval. `tx_line` changes only in the cycle after a tick, and a load happens only on a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Single-cycle bit-period enable |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | 8 | Byte to send |
| cfg_seven_bits | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| cfg_parity_en | input | 1 | Adds a parity bit |
| cfg_parity_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_mpb_en | input | 1 | Sends a forced extra bit in place of parity |
| cfg_mpb_val | input | 1 | Value of the forced extra bit |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| irq_empty_en | input | 1 | Enable for the buffer-empty interrupt |
| irq_end_en | input | 1 | Enable for the transmission-end interrupt |
| tx_line | output | 1 | Serial output, idles high |
| flag_empty | output | 1 | Holding register free |
| flag_end | output | 1 | Transmission finished, line at mark |
| irq_empty | output | 1 | Buffer-empty interrupt request |
| irq_end | output | 1 | Transmission-end interrupt request |

## Verification
The bench decodes the line at every tick and measures the idle bits between frames. A byte queued during a frame must start right after the stop bits. A design that polls only at the end of the stop bit, or that passes through idle first, shows up as a gap of one or more bits. It also shows up if it sends a stop bit too few or too many, since the next start bit is then read as a stop or as data.

An overwrite of a pending byte must produce one frame, not two. The extra bit is driven through parity of both senses and through the forced value with parity also switched on. A design with its priority reversed sends the wrong bit.

Random bursts with random formats and write timing check that no byte is lost or repeated while the empty flag paces the writes.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_EXTRA = 3'd3,
    ST_STOP1 = 3'd4,
    ST_STOP2 = 3'd5
  } tx_state_e;

  // Frame format captured together with each byte at load time.
  typedef struct packed {
    logic seven;
    logic extra_en;
    logic extra_val;
    logic two_stop;
  } frame_cfg_t;

endpackage

// File: rtl/uart_tx_holdreg.sv
module uart_tx_holdreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              load,
  input  logic              end_set,
  output logic [DATA_W-1:0] hold_data,
  output logic              flag_empty,
  output logic              flag_end
);

  logic [DATA_W-1:0] data_d;
  logic              empty_d;
  logic              end_d;

  // A host write has priority over the load and the end event of the same cycle.
  always_comb begin
    data_d  = hold_data;
    empty_d = flag_empty;
    end_d   = flag_end;
    if (load)    empty_d = 1'b1;
    if (end_set) end_d   = 1'b1;
    if (wr_en) begin
      data_d  = wr_data;
      empty_d = 1'b0;
      end_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_data  <= '0;
      flag_empty <= 1'b1;
      flag_end   <= 1'b1;
    end else begin
      hold_data  <= data_d;
      flag_empty <= empty_d;
      flag_end   <= end_d;
    end
  end

  assert_write_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (!flag_empty && !flag_end));

  assert_load_frees_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !wr_en) |=> flag_empty);

  assert_end_implies_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_end |-> flag_empty);

endmodule

// File: rtl/uart_tx_cfgcalc.sv
module uart_tx_cfgcalc
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic              cfg_seven_bits,
  input  logic              cfg_parity_en,
  input  logic              cfg_parity_odd,
  input  logic              cfg_mpb_en,
  input  logic              cfg_mpb_val,
  input  logic              cfg_two_stop,
  output frame_cfg_t        frame_cfg
);

  localparam logic [DATA_W-1:0] SHORT_MASK = {1'b0, {(DATA_W-1){1'b1}}};

  logic [DATA_W-1:0] masked;
  logic              par_bit;

  always_comb begin
    masked  = cfg_seven_bits ? (data & SHORT_MASK) : data;
    par_bit = (^masked) ^ cfg_parity_odd;
    frame_cfg.seven     = cfg_seven_bits;
    frame_cfg.extra_en  = cfg_mpb_en | cfg_parity_en;
    frame_cfg.extra_val = cfg_mpb_en ? cfg_mpb_val : par_bit;
    frame_cfg.two_stop  = cfg_two_stop;
  end

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              pend,
  input  logic [DATA_W-1:0] hold_data,
  input  frame_cfg_t        next_cfg,
  output logic              load,
  output logic              end_set,
  output logic              tx_line
);

  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(DATA_W - 2);

  tx_state_e         state_q, state_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  frame_cfg_t        cfg_q, cfg_d;
  logic              stop2_q, stop2_d;
  logic              chain_q, chain_d;
  logic              enter_stop;
  logic [CNT_W-1:0]  last_idx;

  always_comb begin
    state_d    = state_q;
    sh_d       = sh_q;
    cnt_d      = cnt_q;
    cfg_d      = cfg_q;
    stop2_d    = stop2_q;
    chain_d    = chain_q;
    load       = 1'b0;
    end_set    = 1'b0;
    enter_stop = 1'b0;
    last_idx   = cfg_q.seven ? LAST_SHORT : LAST_LONG;

    case (state_q)
      ST_IDLE: begin
        if (baud_tick && pend) begin
          load    = 1'b1;
          state_d = ST_START;
        end
      end
      ST_START: begin
        if (baud_tick) begin
          state_d = ST_DATA;
          cnt_d   = '0;
        end
      end
      ST_DATA: begin
        if (baud_tick) begin
          sh_d = sh_q >> 1;
          if (cnt_q == last_idx) begin
            if (cfg_q.extra_en) begin
              state_d = ST_EXTRA;
            end else begin
              state_d    = ST_STOP1;
              enter_stop = 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_EXTRA: begin
        if (baud_tick) begin
          state_d    = ST_STOP1;
          enter_stop = 1'b1;
        end
      end
      ST_STOP1: begin
        if (baud_tick) begin
          if (stop2_q)      state_d = ST_STOP2;
          else if (chain_q) state_d = ST_START;
          else              state_d = ST_IDLE;
        end
      end
      ST_STOP2: begin
        if (baud_tick) state_d = chain_q ? ST_START : ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase

    // Stop-bit entry: the next byte is taken now, or the line is declared done.
    if (enter_stop) begin
      stop2_d = cfg_q.two_stop;
      if (pend) begin
        load    = 1'b1;
        chain_d = 1'b1;
      end else begin
        end_set = 1'b1;
        chain_d = 1'b0;
      end
    end

    if (load) begin
      sh_d  = hold_data;
      cfg_d = next_cfg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      cnt_q   <= '0;
      cfg_q   <= '0;
      stop2_q <= 1'b0;
      chain_q <= 1'b0;
    end else begin
      state_q <= state_d;
      sh_q    <= sh_d;
      cnt_q   <= cnt_d;
      cfg_q   <= cfg_d;
      stop2_q <= stop2_d;
      chain_q <= chain_d;
    end
  end

  always_comb begin
    case (state_q)
      ST_START: tx_line = 1'b0;
      ST_DATA:  tx_line = sh_q[0];
      ST_EXTRA: tx_line = cfg_q.extra_val;
      default:  tx_line = 1'b1;
    endcase
  end

  assert_load_on_tick_R13: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> baud_tick);

  assert_line_steady_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !baud_tick |=> $stable(tx_line));

  assert_end_only_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    end_set |-> !pend);

endmodule

// File: rtl/dbl_uart_tx.sv
module dbl_uart_tx
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cfg_seven_bits,
  input  logic              cfg_parity_en,
  input  logic              cfg_parity_odd,
  input  logic              cfg_mpb_en,
  input  logic              cfg_mpb_val,
  input  logic              cfg_two_stop,
  input  logic              irq_empty_en,
  input  logic              irq_end_en,
  output logic              tx_line,
  output logic              flag_empty,
  output logic              flag_end,
  output logic              irq_empty,
  output logic              irq_end
);

  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic [DATA_W-1:0] hold_data;
  logic              load;
  logic              end_set;
  frame_cfg_t        next_cfg;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  uart_tx_holdreg #(.DATA_W(DATA_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .load       (load),
    .end_set    (end_set),
    .hold_data  (hold_data),
    .flag_empty (flag_empty),
    .flag_end   (flag_end)
  );

  uart_tx_cfgcalc #(.DATA_W(DATA_W)) u_cfg (
    .data           (hold_data),
    .cfg_seven_bits (cfg_seven_bits),
    .cfg_parity_en  (cfg_parity_en),
    .cfg_parity_odd (cfg_parity_odd),
    .cfg_mpb_en     (cfg_mpb_en),
    .cfg_mpb_val    (cfg_mpb_val),
    .cfg_two_stop   (cfg_two_stop),
    .frame_cfg      (next_cfg)
  );

  uart_tx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .baud_tick (baud_tick),
    .pend      (!flag_empty),
    .hold_data (hold_data),
    .next_cfg  (next_cfg),
    .load      (load),
    .end_set   (end_set),
    .tx_line   (tx_line)
  );

  assign irq_empty = flag_empty & irq_empty_en;
  assign irq_end   = flag_end & irq_end_en;

  assert_reset_mark_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(rst_int_n) |-> (tx_line && flag_empty && flag_end));

endmodule

// File: tb/tb_dbl_uart_tx.sv
module tb_dbl_uart_tx;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       cfg_seven_bits = 1'b0, cfg_parity_en = 1'b0, cfg_parity_odd = 1'b0;
  logic       cfg_mpb_en = 1'b0, cfg_mpb_val = 1'b0, cfg_two_stop = 1'b0;
  logic       irq_empty_en = 1'b0, irq_end_en = 1'b0;
  logic       tx_line, flag_empty, flag_end, irq_empty, irq_end;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  logic [7:0] qd [0:255];
  int q_wr = 0, q_rd = 0;

  int rx_phase = 0, rx_n = 0, gap_cnt = 0, last_gap = -1, frames_rx = 0;
  logic [15:0] rx_bits = '0;
  logic last_extra = 1'b0;

  always #2 clk = ~clk;

  dbl_uart_tx dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en), .wr_data(wr_data),
    .cfg_seven_bits(cfg_seven_bits), .cfg_parity_en(cfg_parity_en),
    .cfg_parity_odd(cfg_parity_odd), .cfg_mpb_en(cfg_mpb_en), .cfg_mpb_val(cfg_mpb_val),
    .cfg_two_stop(cfg_two_stop), .irq_empty_en(irq_empty_en), .irq_end_en(irq_end_en),
    .tx_line(tx_line), .flag_empty(flag_empty), .flag_end(flag_end),
    .irq_empty(irq_empty), .irq_end(irq_end)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_extra(input logic [7:0] d);
    if (cfg_mpb_en) return cfg_mpb_val;
    return (^d) ^ cfg_parity_odd;
  endfunction

  // Tick generator: one cycle in four.
  initial begin
    int tcnt = 0;
    forever begin
      @(posedge clk); #1;
      tcnt = (tcnt + 1) % 4;
      baud_tick = (tcnt == 0);
    end
  end

  // Line decoder, sampling each bit period as it closes.
  always @(negedge clk) begin
    if (rst_n && baud_tick) begin
      if (rx_phase == 0) begin
        if (!tx_line) begin
          last_gap = gap_cnt; gap_cnt = 0; rx_phase = 1; rx_n = 0;
        end else gap_cnt++;
      end else begin
        int nd, ne, ns;
        nd = cfg_seven_bits ? 7 : 8;
        ne = (cfg_parity_en || cfg_mpb_en) ? 1 : 0;
        ns = cfg_two_stop ? 2 : 1;
        rx_bits[rx_n] = tx_line;
        rx_n++;
        if (rx_n == nd + ne + ns) begin
          logic [7:0] got, exp;
          got = '0;
          for (int i = 0; i < nd; i++) got[i] = rx_bits[i];
          exp = qd[q_rd[7:0]] & (cfg_seven_bits ? 8'h7F : 8'hFF);
          chk(q_rd < q_wr, "R9 unexpected extra frame", q_rd, q_wr);
          chk(got == exp, "R5 frame data", got, exp);
          if (ne == 1) begin
            last_extra = rx_bits[nd];
            chk(last_extra == exp_extra(exp), "R10/R11 extra bit", last_extra, exp_extra(exp));
          end
          for (int s = 0; s < ns; s++)
            chk(rx_bits[nd+ne+s] == 1'b1, "R12 stop bit", rx_bits[nd+ne+s], 1);
          q_rd++; frames_rx++; rx_phase = 0;
        end
      end
    end
  end

  task automatic wr(input logic [7:0] b, input bit push);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_data = b;
    if (push) begin qd[q_wr[7:0]] = b; q_wr++; end
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic wait_tick();
    do @(negedge clk); while (!baud_tick);
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) wait_tick();
  endtask

  task automatic wait_empty();
    int c = 0;
    @(negedge clk);
    while (!flag_empty && c < 2000) begin @(negedge clk); c++; end
  endtask

  task automatic wait_done();
    int c = 0;
    @(negedge clk);
    while (!flag_end && c < 4000) begin @(negedge clk); c++; end
    chk(flag_end, "R7 end flag reached", flag_end, 1);
    wait_ticks(4);
  endtask

  task automatic set_cfg(input logic [5:0] c);
    {cfg_seven_bits, cfg_parity_en, cfg_parity_odd, cfg_mpb_en, cfg_mpb_val, cfg_two_stop} = c;
  endtask

  initial begin
    int cyc, f0, nb;
    void'($urandom(32'd1234));
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(flag_empty, "R1 flag_empty", flag_empty, 1);
    chk(flag_end, "R1 flag_end", flag_end, 1);
    chk(tx_line, "R1 tx_line", tx_line, 1);
    chk(!irq_empty && !irq_end, "R4/R8 irqs masked", {irq_empty, irq_end}, 0);
    irq_empty_en = 1'b1; irq_end_en = 1'b1;
    #1;
    chk(irq_empty, "R4 irq_empty enabled", irq_empty, 1);
    chk(irq_end, "R8 irq_end enabled", irq_end, 1);

    // R2, R3: single 8N1 frame
    set_cfg(6'b000000);
    wait_tick();
    wr(8'hA5, 1);
    @(negedge clk);
    chk(!flag_empty && !flag_end, "R2 flags cleared", {flag_empty, flag_end}, 0);
    chk(!irq_empty && !irq_end, "R4/R8 irqs follow flags", {irq_empty, irq_end}, 0);
    cyc = 0;
    while (!flag_empty && cyc < 20) begin @(negedge clk); cyc++; end
    chk(flag_empty && cyc <= 5, "R3 load at next tick", cyc, 5);
    chk(irq_empty, "R4 irq_empty after load", irq_empty, 1);
    wait_done();
    chk(frames_rx == 1, "R5 one frame sent", frames_rx, 1);
    chk(irq_end, "R8 irq_end after frame", irq_end, 1);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (i == 7) chk(tx_line, "R7 mark state held", tx_line, 1);
    end
    irq_end_en = 1'b0; #1;
    chk(!irq_end, "R8 irq_end masked", irq_end, 0);

    // R6: queued byte follows without gap
    wr(8'h3C, 1);
    wait_empty();
    wr(8'hC3, 1);
    chk(!flag_empty, "R2 second byte pending", flag_empty, 0);
    wait_done();
    chk(last_gap == 0, "R6 no idle between frames", last_gap, 0);

    // R9: overwrite of pending byte
    f0 = frames_rx;
    wait_tick();
    wr(8'h11, 0);
    wr(8'h22, 1);
    wait_done();
    chk(frames_rx == f0 + 1, "R9 single frame after overwrite", frames_rx - f0, 1);

    // R10: even and odd parity on 0x07
    set_cfg(6'b010000); wr(8'h07, 1); wait_done();
    chk(last_extra == 1'b1, "R10 even parity", last_extra, 1);
    set_cfg(6'b011000); wr(8'h07, 1); wait_done();
    chk(last_extra == 1'b0, "R10 odd parity", last_extra, 0);

    // R11: forced bit overrides parity
    set_cfg(6'b011110); wr(8'h01, 1); wait_done();
    chk(last_extra == 1'b1, "R11 forced extra bit", last_extra, 1);

    // R12: seven bits, two stops, chained
    set_cfg(6'b110001);
    wr(8'hFF, 1); wait_empty(); wr(8'h80, 1);
    wait_done();
    chk(last_gap == 0, "R12 two stops then next start", last_gap, 0);

    // Random bursts
    for (int b = 0; b < 40; b++) begin
      set_cfg(6'($urandom()));
      nb = 1 + int'($urandom() % 3);
      for (int k = 0; k < nb; k++) begin
        wait_empty();
        repeat ($urandom() % 20) @(posedge clk);
        wr(8'($urandom()), 1);
      end
      wait_done();
      chk(frames_rx == q_wr, "R5 random burst frame count", frames_rx, q_wr);
      chk(tx_line, "R7 line idle after burst", tx_line, 1);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", frames_rx, q_wr);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule